// File: doc/BRIEF.md
# SAR ADC Serial Control Sequencer

This block is the digital control core of a multichannel successive-approximation converter. It receives an 8-bit command over a serial clock and data pair. The command picks the channel and the input mode: single-ended or differential, unipolar or bipolar, and the gain, which together give the span. It also carries a power-down code. The block opens the sampling window partway through the command. A rising convert strobe then closes the window and starts a conversion. The block runs a binary search against a one-bit comparator decision, working from the most significant bit down. It places the finished code in an output shift register, which is read out on the serial data line.

The analog multiplexer, the attenuators, the capacitive DAC and the comparator lie outside the block. They appear only as the trial DAC code, the configuration outputs and the comparator input. Every input, including the serial clock and the strobe, is sampled by the single system clock, so edges are detected one clock late. The result width is a parameter of 12, 14 or 16 bits. A second parameter gives the minimum sampling time in system clocks. At 100 MHz, 400 clocks is 4 µs.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, acq_open, acq_short and sdo are 0 and every configuration output is 0.
- R2: Outside a conversion, the first eight rising sck edges after reset, or after a conversion start, shift sdi in MSB first. On the eighth edge the word takes effect: bit 7 drives diff_mode, bits 6:4 drive chan, bit 3 drives bipolar, bit 2 drives gain and bits 1:0 drive pd_mode. Further rising edges before the next conversion start do not change the configuration.
- R3: acq_open rises after the sixth falling sck edge of a command word and not after the fifth.
- R4: A rising convst while acq_open is 1 and busy is 0 makes busy 1 on the next clock. busy then stays 1 for exactly W clocks, and acq_open returns to 0.
- R5: The conversion tries bits from MSB to LSB. The first trial code is a 1 in the MSB with all other bits 0. A trial bit is kept when cmp_in is 1, meaning the input is at or above the trial code. The result is the largest code for which the comparator reports at or above.
- R6: convst edges and sck edges that occur while busy is 1 have no effect on the conversion, its length, its result or the configuration.
- R7: A rising convst while acq_open is 0 does not start a conversion.
- R8: At the end of a conversion the result is loaded into the output register. sdo presents the result MSB first and moves to the next bit on each falling sck edge outside a conversion.
- R9: At each conversion start, acq_short is set to 1 if acq_open had been high for fewer than ACQ_CYC clocks, and to 0 otherwise. The value holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial command data |
| convst | input | 1 | Convert strobe, rising edge starts a conversion |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial code |
| sdo | output | 1 | Serial result data, MSB first |
| busy | output | 1 | High during conversion |
| acq_open | output | 1 | Sampling window open |
| acq_short | output | 1 | Sampling time was below minimum at last start |
| dac_code | output | W | Trial code to the capacitive DAC |
| chan | output | 3 | Channel address |
| diff_mode | output | 1 | Differential input selected |
| bipolar | output | 1 | Bipolar range selected |
| gain | output | 1 | Span select (5 V or 10 V) |
| pd_mode | output | 2 | Power-down code |

## Verification
The bench models the comparator as a comparison of the trial code against a programmed input level. It converts an alternating pattern with both halves mixed, the pattern 0x555, full scale and zero. The mixed and alternating patterns show whether each trial bit is kept or cleared at its own position and in the right order. Full scale shows that every bit is kept, and zero shows that every bit is cleared. One conversion is disturbed by a second strobe and by serial clock activity, to show that neither can extend, restart or reconfigure it. Another strobe arrives with no sampling window open, to show that it is refused.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W       = 12,
  parameter int ACQ_CYC = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         sdi,
  input  logic         convst,
  input  logic         cmp_in,
  output logic         sdo,
  output logic         busy,
  output logic         acq_open,
  output logic         acq_short,
  output logic [W-1:0] dac_code,
  output logic [2:0]   chan,
  output logic         diff_mode,
  output logic         bipolar,
  output logic         gain,
  output logic [1:0]   pd_mode
);
  localparam int IW = $clog2(W);
  localparam int CW = $clog2(ACQ_CYC + 1);

  logic          sck_q, cv_q;
  logic [3:0]    bcnt;
  logic [6:0]    sh;
  logic [7:0]    cfg;
  logic [W-1:0]  sar, osr;
  logic [IW-1:0] idx;
  logic [CW-1:0] acnt;

  wire sck_r = sck & ~sck_q;
  wire sck_f = ~sck & sck_q;
  wire start = convst & ~cv_q & acq_open & ~busy;

  wire [W-1:0] trial = sar | ({{(W-1){1'b0}}, 1'b1} << idx);
  wire [W-1:0] keep  = cmp_in ? trial : sar;

  assign dac_code  = busy ? trial : sar;
  assign sdo       = osr[W-1];
  assign diff_mode = cfg[7];
  assign chan      = cfg[6:4];
  assign bipolar   = cfg[3];
  assign gain      = cfg[2];
  assign pd_mode   = cfg[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cv_q      <= 1'b0;
      bcnt      <= '0;
      sh        <= '0;
      cfg       <= '0;
      sar       <= '0;
      osr       <= '0;
      idx       <= '0;
      acnt      <= '0;
      busy      <= 1'b0;
      acq_open  <= 1'b0;
      acq_short <= 1'b0;
    end else begin
      sck_q <= sck;
      cv_q  <= convst;
      if (start) begin
        busy      <= 1'b1;
        acq_open  <= 1'b0;
        bcnt      <= '0;
        sar       <= '0;
        idx       <= IW'(W - 1);
        acq_short <= (acnt < CW'(ACQ_CYC));
      end else if (busy) begin
        sar <= keep;
        if (idx == '0) begin
          busy <= 1'b0;
          osr  <= keep;
        end else begin
          idx <= idx - 1'b1;
        end
      end else begin
        if (acq_open && acnt != CW'(ACQ_CYC)) acnt <= acnt + 1'b1;
        if (sck_r && bcnt < 4'd8) begin
          sh   <= {sh[5:0], sdi};
          bcnt <= bcnt + 1'b1;
          if (bcnt == 4'd7) cfg <= {sh, sdi};
        end
        if (sck_f) begin
          osr <= osr << 1;
          if (bcnt == 4'd6) begin
            acq_open <= 1'b1;
            acnt     <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W       = 12,
  parameter int ACQ_CYC = 400
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         acq_open,
  input logic [W-1:0] dac_code,
  input logic [2:0]   chan,
  input logic         diff_mode,
  input logic         bipolar,
  input logic         gain,
  input logic [1:0]   pd_mode
);
  logic [7:0] blen;
  wire  [7:0] cfg_now = {diff_mode, chan, bipolar, gain, pd_mode};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;

  p_start_from_acq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acq_open));
  p_acq_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !acq_open);
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blen == 8'(W));
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_now));
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_open && busy));
  p_first_trial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == {1'b1, {(W-1){1'b0}}});
endmodule

bind sar_seq sar_seq_chk #(.W(W), .ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .acq_open(acq_open),
  .dac_code(dac_code), .chan(chan), .diff_mode(diff_mode),
  .bipolar(bipolar), .gain(gain), .pd_mode(pd_mode)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int W   = 12;
  localparam int ACQ = 400;

  logic clk = 0, rst_n = 0, sck = 0, sdi = 0, convst = 0;
  logic sdo, busy, acq_open, acq_short, diff_mode, bipolar, gain;
  logic [W-1:0] dac_code;
  logic [2:0] chan;
  logic [1:0] pd_mode;
  int vin = 0;
  int total = 0, bad = 0;
  logic [15:0] rx;
  logic [15:0] acq_log;

  wire cmp_in = (int'(dac_code) <= vin);

  sar_seq #(.W(W), .ACQ_CYC(ACQ)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .convst(convst),
    .cmp_in(cmp_in), .sdo(sdo), .busy(busy), .acq_open(acq_open),
    .acq_short(acq_short), .dac_code(dac_code), .chan(chan),
    .diff_mode(diff_mode), .bipolar(bipolar), .gain(gain), .pd_mode(pd_mode)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input int n);
    rx = '0; acq_log = '0;
    for (int k = 0; k < n; k++) begin
      sdi = (k < 8) ? w[7-k] : 1'b0;
      repeat (4) @(negedge clk);
      sck = 1;
      repeat (4) @(negedge clk);
      rx = {rx[14:0], sdo};
      sck = 0;
      repeat (2) @(negedge clk);
      acq_log[k] = acq_open;
    end
  endtask

  task automatic chk_cfg(input string req, input logic [7:0] w);
    chk(req, {diff_mode, chan, bipolar, gain, pd_mode}, w);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 acq", acq_open, 0);
    chk("R1 short", acq_short, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 cfg", {diff_mode, chan, bipolar, gain, pd_mode}, 0);
  endtask

  task automatic t_word(input logic [7:0] w, input int exp_res);
    send_word(w, W);
    chk_cfg("R2 fields", w);
    chk("R3 closed after fall 5", acq_log[4], 0);
    chk("R3 open after fall 6", acq_log[5], 1);
    chk("R8 readout", int'(rx[W-1:0]), exp_res);
  endtask

  task automatic t_conv(input int v, input int exp_short, input bit poke);
    int cnt = 0;
    logic [7:0] cfg0 = {diff_mode, chan, bipolar, gain, pd_mode};
    vin = v;
    @(negedge clk); convst = 1;
    @(negedge clk); convst = 0;
    chk("R4 busy rises", busy, 1);
    chk("R4 acq closes", acq_open, 0);
    while (busy && cnt < 100) begin
      cnt++;
      if (poke && cnt == 3) begin convst = 1; sck = 1; sdi = 1; end
      if (poke && cnt == 5) convst = 0;
      if (poke && cnt == 7) sck = 0;
      @(negedge clk);
    end
    sdi = 0;
    chk(poke ? "R6 length unchanged" : "R4 busy length", cnt, W);
    chk("R9 acq_short", acq_short, exp_short);
    if (poke) chk_cfg("R6 cfg unchanged", cfg0);
  endtask

  task automatic t_no_acq();
    @(negedge clk); convst = 1;
    @(negedge clk); convst = 0;
    repeat (3) @(negedge clk);
    chk("R7 no start without acq", busy, 0);
  endtask

  task automatic t_extra_rises();
    for (int k = 0; k < 2; k++) begin
      sdi = 1;
      repeat (4) @(negedge clk); sck = 1;
      repeat (4) @(negedge clk); sck = 0;
    end
    sdi = 0;
    repeat (2) @(negedge clk);
    chk_cfg("R2 extra rises ignored", 8'h3B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_word(8'hD6, 0);
    t_conv(12'hA5A, 1, 0);
    t_no_acq();
    t_word(8'h3B, 12'hA5A);
    t_extra_rises();
    repeat (ACQ + 20) @(negedge clk);
    t_conv(12'h555, 0, 1);
    t_word(8'h80, 12'h555);
    t_conv(4095, 1, 0);
    t_word(8'h01, 12'hFFF);
    t_conv(0, 1, 0);
    t_word(8'h7C, 0);
    chk("R5 final trial code", int'(dac_code), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule